// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio N = B*P + A and is meant for the feedback path of a frequency synthesizer. Internally it runs a prescaler that divides by either P or P+1. A swallow count A steers the prescaler and a main count B counts prescaler cycles. For the first A prescaler cycles of each output period the prescaler runs at P+1. For the remaining B-A cycles it runs at P. After B prescaler cycles the block emits one single-cycle output pulse and starts the next period.

Settings are written into a holding register through a one-cycle load strobe, and that register is checked for legality on entry. An accepted setting waits in the holding register and is copied into the running configuration only at the end of the current output period. This means no period is ever cut short or stretched by a write. A rejected setting raises an error flag, and the block keeps running on its last accepted setting.

Top module: `psw_divider`

## Requirements
- R1: The interval between consecutive rising edges of `div_out` equals B*P + A input clock cycles for the active setting.
- R2: `cfg_sel` chooses the prescaler pair: 0 selects 8/9, 1 selects 16/17, 2 selects 32/33, 3 selects 64/65.
- R3: `mod_hi` is high for exactly A*(P+1) input cycles in each output period, during the first A prescaler cycles, and is low for the remaining cycles.
- R4: `div_out` is high for exactly one input cycle per output period.
- R5: A setting accepted during an output period does not change that period; it governs the period that starts after the next `div_out` pulse.
- R6: A load whose B is below 3 or below A is rejected. From the next cycle `cfg_err` reads 1 and the output period is unchanged. A later accepted load clears `cfg_err`.
- R7: A load sampled on the same clock edge that ends an output period is not applied at that boundary; it takes effect one period later.
- R8: During reset `div_out`, `mod_hi` and `cfg_err` are 0. After reset the active setting is P=8, A=0, B=3, and the first pulse appears 24 cycles after reset is released.
- R9: The full field ranges are accepted: A is 6 bits (0..63) and B is 13 bits (3..8191), so for example A=63, B=1000 with P=8 yields N=8063.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-cycle strobe that offers a new setting to the holding register |
| cfg_sel | input | 2 | Prescaler pair select (0:8/9, 1:16/17, 2:32/33, 3:64/65) |
| cfg_a | input | 6 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| mod_hi | output | 1 | Prescaler modulus control, high while dividing by P+1 |
| cfg_err | output | 1 | High after a rejected load, cleared by an accepted one |

## Verification
The one collision that matters is a load landing on the period-ending edge, the same edge where the counters reload from the adopted setting. The bench provokes it by counting cycles from a pulse, so that the strobe is sampled exactly on the edge of period N. The bench then checks that the following period still has the old length and that the one after has the new length. Around that case, the bench sweeps every prescaler pair against small A and B values. For each setting it computes the period length and the time spent at P+1 with its own arithmetic, and it checks that each write takes effect exactly one period after it is made.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int A_W     = 6;
  localparam int B_W     = 13;
  localparam int SEL_W   = 2;
  localparam int PMIN_LG = 3;
  localparam int B_MIN   = 3;
  // count index reaches P+1-1 = largest P, so one bit above its log2
  localparam int PC_W    = PMIN_LG + (1 << SEL_W);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [A_W-1:0]   a;
    logic [B_W-1:0]   b;
  } div_cfg_t;

  localparam div_cfg_t CFG_RST = '{sel: '0, a: '0, b: B_W'(B_MIN)};

  // base modulus P for a select code
  function automatic logic [PC_W-1:0] base_mod(input logic [SEL_W-1:0] sel);
    return PC_W'(1) << (PMIN_LG + int'(sel));
  endfunction

  // legality rule: B must be at least the minimum and at least A
  function automatic logic cfg_ok(input div_cfg_t c);
    return (c.b >= B_W'(B_MIN)) && (c.b >= B_W'(c.a));
  endfunction
endpackage

// File: rtl/psw_cfg_hold.sv
module psw_cfg_hold
  import psw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  div_cfg_t wr_cfg,
  input  logic     cycle_end,
  output div_cfg_t act_cfg,
  output div_cfg_t nxt_cfg,
  output logic     pend,
  output logic     cfg_err
);
  div_cfg_t hold_q;
  div_cfg_t act_q;
  logic     wr_ok;

  assign wr_ok   = cfg_ok(wr_cfg);
  // setting the counters reload with at the boundary
  assign nxt_cfg = (cycle_end && pend) ? hold_q : act_q;
  assign act_cfg = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= CFG_RST;
      act_q   <= CFG_RST;
      pend    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (cycle_end) begin
        act_q <= nxt_cfg;
        pend  <= 1'b0;
      end
      // a load on the boundary edge re-arms pend for the next period
      if (wr_en) begin
        cfg_err <= !wr_ok;
        if (wr_ok) begin
          hold_q <= wr_cfg;
          pend   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             mod_hi,
  output logic             pre_tc,
  output logic [PC_W-1:0]  pcnt
);
  logic [PC_W-1:0] modulus;

  assign modulus = base_mod(sel) + PC_W'(mod_hi);
  assign pre_tc  = (pcnt == modulus - PC_W'(1));

  always_ff @(posedge clk) begin
    if (rst || pre_tc) pcnt <= '0;
    else               pcnt <= pcnt + PC_W'(1);
  end
endmodule

// File: rtl/psw_counters.sv
module psw_counters
  import psw_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           pre_tc,
  input  logic [A_W-1:0] nxt_a,
  input  logic [B_W-1:0] nxt_b,
  output logic           mod_hi,
  output logic           cycle_end,
  output logic [A_W-1:0] a_rem,
  output logic [B_W-1:0] b_rem
);
  assign mod_hi    = (a_rem != '0);
  assign cycle_end = pre_tc && (b_rem == B_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rem <= CFG_RST.a;
      b_rem <= CFG_RST.b;
    end else if (cycle_end) begin
      a_rem <= nxt_a;
      b_rem <= nxt_b;
    end else if (pre_tc) begin
      b_rem <= b_rem - B_W'(1);
      if (mod_hi) a_rem <= a_rem - A_W'(1);
    end
  end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [A_W-1:0]   cfg_a,
  input  logic [B_W-1:0]   cfg_b,
  output logic             div_out,
  output logic             mod_hi,
  output logic             cfg_err
);
  div_cfg_t        wr_cfg;
  div_cfg_t        act_cfg;
  div_cfg_t        nxt_cfg;
  logic            pend;
  logic            pre_tc;
  logic            cycle_end;
  logic [PC_W-1:0] pcnt;
  logic [A_W-1:0]  a_rem;
  logic [B_W-1:0]  b_rem;
  logic [SEL_W-1:0] act_sel;
  logic [A_W-1:0]  act_a;
  logic [B_W-1:0]  act_b;

  assign wr_cfg  = '{sel: cfg_sel, a: cfg_a, b: cfg_b};
  assign act_sel = act_cfg.sel;
  assign act_a   = act_cfg.a;
  assign act_b   = act_cfg.b;

  psw_cfg_hold u_hold (
    .clk(clk), .rst(rst), .wr_en(cfg_load), .wr_cfg(wr_cfg),
    .cycle_end(cycle_end), .act_cfg(act_cfg), .nxt_cfg(nxt_cfg),
    .pend(pend), .cfg_err(cfg_err)
  );

  psw_prescaler u_pre (
    .clk(clk), .rst(rst), .sel(act_sel), .mod_hi(mod_hi),
    .pre_tc(pre_tc), .pcnt(pcnt)
  );

  psw_counters u_cnt (
    .clk(clk), .rst(rst), .pre_tc(pre_tc),
    .nxt_a(nxt_cfg.a), .nxt_b(nxt_cfg.b),
    .mod_hi(mod_hi), .cycle_end(cycle_end),
    .a_rem(a_rem), .b_rem(b_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= cycle_end;
  end
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk
  import psw_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic             div_out,
  input logic             mod_hi,
  input logic             cfg_err,
  input logic             pre_tc,
  input logic             cycle_end,
  input logic             pend,
  input logic [SEL_W-1:0] act_sel,
  input logic [A_W-1:0]   act_a,
  input logic [B_W-1:0]   act_b
);
  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  // R1
  end_on_tc_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> pre_tc);

  // R1
  pulse_follows_end_chk: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> div_out);

  // R3
  swallow_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_hi) |-> $past(pre_tc));

  // R5
  cfg_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_sel) || !$stable(act_a) || !$stable(act_b)) |-> $past(cycle_end));

  // R6
  legal_active_chk: assert property (@(posedge clk) disable iff (rst)
    (act_b >= B_W'(B_MIN)) && (act_b >= B_W'(act_a)));

  // R7
  load_arms_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_load) && !cfg_err) |-> pend);
endmodule

bind psw_divider psw_divider_chk u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .div_out(div_out),
  .mod_hi(mod_hi), .cfg_err(cfg_err), .pre_tc(pre_tc),
  .cycle_end(cycle_end), .pend(pend), .act_sel(act_sel),
  .act_a(act_a), .act_b(act_b)
);

// File: tb/psw_divider_tb.sv
module psw_divider_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_a = '0;
  logic [12:0] cfg_b = 13'd3;
  logic        div_out, mod_hi, cfg_err;

  int errors = 0;
  int checks = 0;
  int cur_s = 0, cur_a = 0, cur_b = 3;

  always #10 clk = ~clk;

  psw_divider u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
    .cfg_a(cfg_a), .cfg_b(cfg_b), .div_out(div_out), .mod_hi(mod_hi),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pval(input int s);
    int p = 8;
    for (int i = 0; i < s; i++) p = p + p;
    return p;
  endfunction

  function automatic int n_of(input int s, input int a, input int b);
    int n = a;
    for (int i = 0; i < b; i++) n = n + pval(s);
    return n;
  endfunction

  // starts on the negedge where div_out is seen high; returns on the next one
  task automatic period(input bit wr, input int at, input int s, input int a,
                        input int b, output int len, output int mh);
    len = 0;
    mh  = 0;
    do begin
      len++;
      if (mod_hi) mh++;
      cfg_load = wr && (len == at);
      if (wr && len == at) begin
        cfg_sel = 2'(s);
        cfg_a   = 6'(a);
        cfg_b   = 13'(b);
      end
      @(negedge clk);
    end while (!div_out && len < 600000);
    cfg_load = 1'b0;
  endtask

  // write a new setting early; the period measured still belongs to the old one
  task automatic step_to(input int s, input int a, input int b);
    int len, mh;
    period(1'b1, 2, s, a, b, len, mh);
    chk("R1 R2 R5 period", len, n_of(cur_s, cur_a, cur_b));
    chk("R3 mod_hi cycles", mh, cur_a * (pval(cur_s) + 1));
    cur_s = s; cur_a = a; cur_b = b;
  endtask

  initial begin
    int len, mh, w;
    repeat (3) @(negedge clk);
    chk("R8 div_out in reset", int'(div_out), 0);
    chk("R8 mod_hi in reset", int'(mod_hi), 0);
    chk("R8 cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
    w = 0;
    do begin @(negedge clk); w++; end while (!div_out && w < 1000);
    chk("R8 first pulse delay", w, 24);

    period(1'b0, 0, 0, 0, 0, len, mh);
    chk("R8 default period", len, 24);
    chk("R4 single-cycle pulse", int'(len > 1), 1);

    for (int s = 0; s < 4; s++)
      for (int b = 3; b <= 6; b++)
        for (int a = 0; a <= ((b < 5) ? b : 5); a++)
          step_to(s, a, b);

    step_to(0, 63, 1000);            // R9
    step_to(0, 1, 3);                // R9 period 8063 measured here

    period(1'b1, 2, 1, 5, 4, len, mh);   // B below A
    chk("R6 period kept", len, 25);
    chk("R6 err after B<A", int'(cfg_err), 1);
    period(1'b1, 2, 0, 0, 2, len, mh);   // B below minimum
    chk("R6 period unchanged", len, 25);
    chk("R6 err after B<3", int'(cfg_err), 1);
    period(1'b0, 0, 0, 0, 0, len, mh);
    chk("R6 rejected not applied", len, 25);

    period(1'b1, 2, 1, 0, 3, len, mh);
    chk("R6 legal write period", len, 25);
    chk("R6 err cleared", int'(cfg_err), 0);
    cur_s = 1; cur_a = 0; cur_b = 3;

    period(1'b1, 48, 2, 2, 4, len, mh);  // strobe on the boundary edge
    chk("R7 collision period", len, 48);
    period(1'b0, 0, 0, 0, 0, len, mh);
    chk("R7 not adopted at boundary", len, 48);
    period(1'b0, 0, 0, 0, 0, len, mh);
    chk("R7 adopted one period later", len, n_of(2, 2, 4));
    chk("R3 mod_hi after collision", mh, 2 * 33);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule